// File: doc/BRIEF.md
# Conversion Result Holding Register with Read Lock

This block keeps the latest 10-bit sample produced by an analog-to-digital converter. It presents that sample to a processor bus as two read-only 8-bit bytes. A byte-address bit selects the byte: 0 is the low byte and 1 is the high byte. The converter delivers each finished sample with a one-cycle valid strobe. An alignment input chooses how the 10 bits sit inside the 16-bit pair: packed toward bit 0 (right-aligned, the default when the input is 0) or packed toward bit 15 (left-aligned).

Multi-byte reads must see one coherent sample. A read of the low byte therefore freezes the visible sample until the high byte has been read. A sample that finishes during that window waits in a one-deep pending slot. When a second sample displaces a waiting one, a sticky overrun flag is raised, and software clears it with a dedicated pulse. A high-byte read on its own never freezes anything. Left-aligned 8-bit readers can therefore poll only the high byte and always see fresh data.

Top module: `adcres_reg`

## Requirements
- R1: After reset, both bytes read as zero and the overrun flag is 0.
- R2: With right alignment (align_left=0), address 0 returns sample bits 7..0. Address 1 returns bits 9..8 in its bits 1..0, with zeros above.
- R3: With left alignment (align_left=1), address 1 returns sample bits 9..2. Address 0 returns bits 1..0 in its bits 7..6, with zeros below.
- R4: A read at address 0 locks the visible sample, including against a strobe in that same cycle. No later strobe changes the visible sample until a read at address 1.
- R5: A read at address 1 while unlocked does not lock. Every new strobe remains visible from the next cycle onward.
- R6: A sample that arrived while locked becomes visible in the cycle after the unlocking address-1 read.
- R7: A strobe that arrives while a sample is already pending replaces the pending sample and sets the overrun flag, which stays set.
- R8: An ovr_clr pulse clears the overrun flag in the next cycle. A simultaneous new overrun wins and keeps the flag set.
- R9: Changing align_left changes the byte view in the same cycle, without altering the stored 10-bit sample.
- R10: A strobe in the same cycle as the unlocking address-1 read becomes visible in the next cycle. It takes precedence over any pending sample, which is dropped.
- R11: When rd_en is 0, rd_data is zero.
- R12: While unlocked, and with no address-0 read in that cycle, a strobed sample is visible in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | One-cycle strobe: a new sample is ready |
| res_data | input | 10 | Sample value (RES_W) |
| align_left | input | 1 | 1 packs the sample toward bit 15, 0 toward bit 0 |
| rd_en | input | 1 | Bus read enable |
| rd_addr | input | 1 | Byte select: 0 low byte, 1 high byte |
| rd_data | output | 8 | Combinational read data (BYTE_W) |
| ovr_clr | input | 1 | Pulse that clears the overrun flag |
| ovr_flag | output | 1 | Sticky overrun flag |

## Verification
The bench builds the block with its defaults: a 10-bit sample in 8-bit bytes. This leaves a six-bit gap between the sample and the 16-bit pair, so both alignments place bits on either side of the byte boundary. Random interleavings of strobes, low reads, high reads and clear pulses reach the lock-then-overrun and bypass-at-unlock orderings many times. Directed sequences pin down the same-cycle collisions: a strobe with a low read, a strobe with the unlocking read, and a clear pulse with an overrun.

// File: rtl/adcres_pkg.sv
package adcres_pkg;

  typedef enum logic {
    SEL_LO = 1'b0,
    SEL_HI = 1'b1
  } byte_sel_e;

  typedef enum logic {
    ALIGN_RIGHT = 1'b0,
    ALIGN_LEFT  = 1'b1
  } align_e;

endpackage

// File: rtl/adcres_hold.sv
module adcres_hold #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_valid,
  input  logic [RES_W-1:0] res_data,
  input  logic             lo_rd,
  input  logic             hi_rd,
  input  logic             ovr_clr,
  output logic [RES_W-1:0] vis_q,
  output logic             ovr_q,
  output logic             locked_q,
  output logic             unlock_ev,
  output logic             park_ev,
  output logic             overrun_ev
);

  logic [RES_W-1:0] pend_q;
  logic             pend_v_q;
  logic             blocked;

  // Named internal events
  assign unlock_ev  = locked_q && hi_rd;
  assign blocked    = (locked_q || lo_rd) && !unlock_ev;
  assign park_ev    = res_valid && blocked;
  assign overrun_ev = res_valid && pend_v_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vis_q    <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      locked_q <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      if (overrun_ev)   ovr_q <= 1'b1;
      else if (ovr_clr) ovr_q <= 1'b0;

      if (unlock_ev) begin
        locked_q <= 1'b0;
        pend_v_q <= 1'b0;
        if (res_valid)     vis_q <= res_data;
        else if (pend_v_q) vis_q <= pend_q;
      end else begin
        if (lo_rd) locked_q <= 1'b1;
        if (park_ev) begin
          pend_q   <= res_data;
          pend_v_q <= 1'b1;
        end else if (res_valid) begin
          vis_q <= res_data;
        end
      end
    end
  end

  // R4
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && !hi_rd) |=> $stable(vis_q));

  // R6
  pend_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock_ev && pend_v_q && !res_valid) |=> (vis_q == $past(pend_q)));

  // R7
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_ev |=> ovr_q);

  // R8
  overrun_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_clr && !overrun_ev) |=> !ovr_q);

  // R10
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock_ev && res_valid) |=> (vis_q == $past(res_data)));

  // R6
  pend_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_ev |=> (!pend_v_q && !locked_q));

  // R12
  direct_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !locked_q && !lo_rd) |=> (vis_q == $past(res_data)));

endmodule

// File: rtl/adcres_view.sv
module adcres_view #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              align_left,
  input  logic [RES_W-1:0]  vis,
  input  logic              rd_en,
  input  logic              rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  import adcres_pkg::*;

  localparam int WORD_W = 2 * BYTE_W;
  localparam int LSHIFT = WORD_W - RES_W;

  generate
    if (RES_W > WORD_W || RES_W < 1) begin : g_bad_width
      initial $error("adcres_view: RES_W must fit in two bytes");
    end
  endgenerate

  function automatic logic [WORD_W-1:0] pack_word(input logic [RES_W-1:0] v,
                                                  input align_e a);
    logic [WORD_W-1:0] w;
    w = WORD_W'(v);
    if (a == ALIGN_LEFT) w = w << LSHIFT;
    return w;
  endfunction

  logic [WORD_W-1:0] word;

  always_comb begin
    word = pack_word(vis, align_e'(align_left));
    if (!rd_en)                          rd_data = '0;
    else if (byte_sel_e'(rd_addr) == SEL_HI) rd_data = word[WORD_W-1:BYTE_W];
    else                                 rd_data = word[BYTE_W-1:0];
  end

endmodule

// File: rtl/adcres_reg.sv
module adcres_reg #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [RES_W-1:0]  res_data,
  input  logic              align_left,
  input  logic              rd_en,
  input  logic              rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              ovr_clr,
  output logic              ovr_flag
);
  import adcres_pkg::*;

  logic             lo_rd;
  logic             hi_rd;
  logic [RES_W-1:0] vis;
  logic             locked;
  logic             unlock_ev;
  logic             park_ev;
  logic             overrun_ev;

  assign lo_rd = rd_en && (byte_sel_e'(rd_addr) == SEL_LO);
  assign hi_rd = rd_en && (byte_sel_e'(rd_addr) == SEL_HI);

  adcres_hold #(.RES_W(RES_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .res_valid  (res_valid),
    .res_data   (res_data),
    .lo_rd      (lo_rd),
    .hi_rd      (hi_rd),
    .ovr_clr    (ovr_clr),
    .vis_q      (vis),
    .ovr_q      (ovr_flag),
    .locked_q   (locked),
    .unlock_ev  (unlock_ev),
    .park_ev    (park_ev),
    .overrun_ev (overrun_ev)
  );

  adcres_view #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_view (
    .align_left (align_left),
    .vis        (vis),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data)
  );

  // R11
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == '0));

  // R5
  hi_no_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_rd && !locked) |=> !locked);

  // R4
  lo_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd |=> locked);

  // R4
  park_only_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    park_ev |-> (locked || lo_rd) && !unlock_ev);

endmodule

// File: tb/adcres_reg_test.sv
module adcres_reg_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       res_valid = 1'b0;
  logic [9:0] res_data = '0;
  logic       align_left = 1'b0;
  logic       rd_en = 1'b0;
  logic       rd_addr = 1'b0;
  logic [7:0] rd_data;
  logic       ovr_clr = 1'b0;
  logic       ovr_flag;

  int checks = 0;
  int errors = 0;

  // Bench reference state
  logic [9:0] m_vis = '0;
  logic [9:0] m_pend = '0;
  logic       m_pv = 1'b0;
  logic       m_lock = 1'b0;
  logic       m_ovr = 1'b0;

  always #5 clk = ~clk;

  adcres_reg uut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .align_left(align_left), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .ovr_clr(ovr_clr), .ovr_flag(ovr_flag)
  );

  function automatic logic [7:0] exp_byte(input logic [9:0] v, input logic left,
                                          input logic en, input logic hi);
    if (!en) return 8'h00;
    if (left) return hi ? v[9:2] : {v[1:0], 6'b000000};
    return hi ? {6'b000000, v[9:8]} : v[7:0];
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic v, input logic [9:0] d,
                      input logic al, input logic en, input logic ad,
                      input logic clr);
    logic lo, hi, unl;
    @(negedge clk);
    res_valid = v; res_data = d; align_left = al;
    rd_en = en; rd_addr = ad; ovr_clr = clr;
    #1;
    check(tag, "rd_data", {2'b00, rd_data}, {2'b00, exp_byte(m_vis, al, en, ad)});
    check(tag, "ovr_flag", {9'd0, ovr_flag}, {9'd0, m_ovr});
    @(posedge clk);
    lo  = en && !ad;
    hi  = en && ad;
    unl = m_lock && hi;
    if (v && m_pv) m_ovr = 1'b1;
    else if (clr)  m_ovr = 1'b0;
    if (unl) begin
      if (v) m_vis = d;
      else if (m_pv) m_vis = m_pend;
      m_pv = 1'b0;
      m_lock = 1'b0;
    end else if (v) begin
      if (m_lock || lo) begin m_pend = d; m_pv = 1'b1; end
      else m_vis = d;
    end
    if (lo) m_lock = 1'b1;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0A1C));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset contents
    step("R1", 0, 0, 0, 1, 0, 0);
    step("R1", 0, 0, 0, 1, 1, 0);
    step("R1", 0, 0, 1, 1, 1, 0);
    // R11 idle bus
    step("R11", 1, 10'h2A5, 0, 0, 0, 0);
    // R12 / R2 direct load, right aligned
    step("R12", 0, 0, 0, 1, 0, 0);
    step("R2", 0, 0, 0, 1, 1, 0);
    // R9 align flip on same stored sample
    step("R9", 0, 0, 1, 1, 1, 0);
    step("R9", 0, 0, 0, 1, 1, 0);
    step("R3", 0, 0, 1, 1, 0, 0);
    step("R3", 0, 0, 1, 1, 1, 0);
    // R4 lock with strobe in the low-read cycle, then more strobes
    step("R4", 1, 10'h155, 0, 1, 0, 0);
    step("R4", 0, 0, 0, 1, 0, 0);
    step("R7", 1, 10'h0F3, 0, 0, 0, 0);
    step("R7", 0, 0, 0, 0, 0, 0);
    step("R4", 0, 0, 0, 1, 1, 0);
    // R6 pending released after unlock
    step("R6", 0, 0, 0, 1, 0, 0);
    step("R6", 0, 0, 0, 1, 1, 0);
    // R8 clear, then clear colliding with overrun
    step("R8", 0, 0, 0, 0, 0, 1);
    step("R8", 0, 0, 0, 1, 0, 0);
    step("R8", 1, 10'h011, 0, 0, 0, 0);
    step("R8", 1, 10'h022, 0, 0, 0, 1);
    step("R8", 0, 0, 0, 0, 0, 0);
    // R10 bypass at unlock, pending dropped
    step("R10", 1, 10'h3C9, 0, 1, 1, 1);
    step("R10", 0, 0, 0, 1, 0, 0);
    step("R10", 0, 0, 0, 1, 1, 0);
    // R5 left-aligned high-only polling
    for (int i = 0; i < 8; i++) begin
      step("R5", 1, 10'($urandom), 1, 1, 1, 0);
      step("R5", 0, 0, 1, 1, 1, 0);
    end

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic al;
      al = ($urandom % 50) == 0 ? ~align_left : align_left;
      step(al ? "R3" : "R2", ($urandom % 10) < 4, 10'($urandom), al,
           ($urandom % 2) == 1, ($urandom % 2) == 1, ($urandom % 20) == 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule